// File: doc/BRIEF.md
# Prioritized Interrupt Acceptance Unit

This block sits between an interrupt source fabric and a processor core. It keeps three 256-bit vector arrays: one for pending requests, one for vectors now being serviced, and one that records the trigger mode of each vector. It also holds a task priority value and a spurious-vector control register. It compares priority classes, each class being 16 consecutive vectors, and from that decides whether to raise the processor's interrupt line. When the core acknowledges, the block returns a vector. When the core signals end of interrupt, it retires the top in-service vector.

A request is accepted only when its class is strictly higher than the processor priority class. The processor priority is the task priority, unless the highest in-service vector has a higher class. In that case it is that vector's class. An acknowledge that finds only blocked requests returns the spurious vector. Retiring a level-triggered vector produces a broadcast strobe, unless directed EOI mode is set.

Top module: `intr_accept_unit`

## Requirements
- R1: After reset the request, in-service and trigger arrays are empty, task priority is 0 and the spurious register is 0x0FF (enable clear). `irq_pending` is low and an acknowledge reports none.
- R2: Spurious register bit 8 is the software enable. While it is 0, `irq_pending` stays low and every acknowledge reports none, with no change to the arrays.
- R3: The pending line is re-evaluated one cycle after a level-triggered request (`req_level`=1), an acknowledge, an EOI, a task priority write or a spurious register write. An edge-triggered request (`req_level`=0) alone leaves `irq_pending` unchanged.
- R4: One cycle after a request, `req_fresh` is 1 if the vector's request bit was clear beforehand, and 0 if it was already set.
- R5: Of several requests, the one with the highest vector number is granted first.
- R6: A task priority write keeps bits 3:0 of the data and stores them as priority bits 7:4. When the processor priority is zero, any request passes. Otherwise a request passes only if its bits 7:4 are strictly greater than the processor priority bits 7:4.
- R7: The processor priority is the task priority when task bits 7:4 are at least the class of the highest in-service vector. Otherwise it is that vector's class with the low nibble zero.
- R8: An acknowledge with requests present but none passing returns `ack_rsp_none`=0 and `ack_rsp_vec` equal to spurious bits 7:0. The arrays do not change.
- R9: A granted acknowledge returns the vector, clears its request bit and sets its in-service bit.
- R10: EOI clears the highest set in-service bit, which lowers the processor priority accordingly. EOI with no in-service bit set has no effect.
- R11: EOI emits `eoi_bcast_valid` with the retired vector when that vector's trigger bit is 1 and spurious bit 12 (directed EOI) is 0. Otherwise no broadcast is emitted.
- R12: An acknowledge with no request bit set reports `ack_rsp_none`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request strobe |
| req_vec | input | 8 | Requested vector |
| req_level | input | 1 | Trigger mode of the request (1 = level) |
| ack_req | input | 1 | Acknowledge strobe from the core |
| eoi_req | input | 1 | End-of-interrupt strobe |
| tpr_we | input | 1 | Task priority write strobe |
| tpr_wdata | input | 8 | Task priority write data |
| svr_we | input | 1 | Spurious register write strobe |
| svr_wdata | input | 13 | Spurious register write data |
| irq_pending | output | 1 | Interrupt line to the core |
| req_fresh | output | 1 | Request bit was newly set (one cycle after request) |
| ack_rsp_valid | output | 1 | Acknowledge response valid |
| ack_rsp_none | output | 1 | Acknowledge found nothing to return |
| ack_rsp_vec | output | 8 | Granted or spurious vector |
| eoi_bcast_valid | output | 1 | EOI broadcast strobe |
| eoi_bcast_vec | output | 8 | Vector carried by the broadcast |

## Verification
Several of the assertions assume that at most one of the request, acknowledge and EOI strobes is active in any cycle. Under that assumption an array change can be traced to one event: a grant, a retirement, or a blocked acknowledge that leaves everything unchanged. The broadcast check also assumes that no request rewrites the retired vector's trigger bit in the same cycle. The directed bench keeps within these assumptions. Each task drives exactly one strobe for one cycle, then leaves a quiet cycle so the re-evaluated pending line settles before it is sampled.

// File: rtl/intr_pkg.sv
// Shared constants for the interrupt acceptance unit.
// Assumes an 8-bit vector space split into 16-vector priority classes.
package intr_pkg;
    localparam int SVR_W        = 13;   // spurious register width
    localparam int SVR_EN_BIT   = 8;    // software enable
    localparam int SVR_DEOI_BIT = 12;   // directed EOI: suppress broadcast
    localparam logic [SVR_W-1:0] SVR_RESET = 13'h0FF;
endpackage

// File: rtl/hi_bit_find.sv
// Finds the highest-numbered set bit of a vector.
// Assumes N is a power of two; idx_o is meaningless when any_o is low.
module hi_bit_find #(
    parameter int N  = 256,
    localparam int IW = $clog2(N)
) (
    input  logic [N-1:0]  vec_i,
    output logic          any_o,
    output logic [IW-1:0] idx_o
);
    // scan upward so the last set bit seen wins
    always_comb begin
        any_o = 1'b0;
        idx_o = '0;
        for (int i = 0; i < N; i++) begin
            if (vec_i[i]) begin
                any_o = 1'b1;
                idx_o = IW'(i);
            end
        end
    end
endmodule

// File: rtl/prio_gate.sv
// Derives the processor priority from the task priority and the top
// in-service vector, then decides whether the top request may pass.
// Assumes class bits are the vector bits above CLS_LSB.
module prio_gate #(
    parameter int VEC_W   = 8,
    parameter int CLS_LSB = 4,
    localparam int CLS_W  = VEC_W - CLS_LSB
) (
    input  logic [VEC_W-1:0] tpr_i,
    input  logic             isr_any_i,
    input  logic [VEC_W-1:0] isr_top_i,
    input  logic             irr_any_i,
    input  logic [VEC_W-1:0] irr_top_i,
    output logic             pass_o
);
    logic [CLS_W-1:0] isr_cls;
    logic [VEC_W-1:0] ppr;

    // processor priority: larger of task priority and in-service class
    always_comb begin
        isr_cls = isr_any_i ? isr_top_i[VEC_W-1:CLS_LSB] : '0;
        if (tpr_i[VEC_W-1:CLS_LSB] >= isr_cls)
            ppr = tpr_i;
        else
            ppr = {isr_cls, {CLS_LSB{1'b0}}};
    end

    // a request passes when ppr is zero or its class is strictly above
    always_comb begin
        pass_o = irr_any_i &&
                 ((ppr == '0) || (irr_top_i[VEC_W-1:CLS_LSB] > ppr[VEC_W-1:CLS_LSB]));
    end
endmodule

// File: rtl/intr_accept_unit.sv
// Prioritized interrupt acceptance: request, in-service and trigger arrays,
// task priority and spurious register; drives the pending line, answers
// acknowledges and retires vectors on EOI.
// Assumes strobes are single-cycle; simultaneous strobes are resolved as
// clear-then-set on the arrays.
module intr_accept_unit
    import intr_pkg::*;
#(
    parameter int VEC_W   = 8,
    parameter int CLS_LSB = 4,
    localparam int NUM_VEC = 1 << VEC_W,
    localparam int TP_W    = VEC_W - CLS_LSB
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic [VEC_W-1:0] req_vec,
    input  logic             req_level,
    input  logic             ack_req,
    input  logic             eoi_req,
    input  logic             tpr_we,
    input  logic [VEC_W-1:0] tpr_wdata,
    input  logic             svr_we,
    input  logic [SVR_W-1:0] svr_wdata,
    output logic             irq_pending,
    output logic             req_fresh,
    output logic             ack_rsp_valid,
    output logic             ack_rsp_none,
    output logic [VEC_W-1:0] ack_rsp_vec,
    output logic             eoi_bcast_valid,
    output logic [VEC_W-1:0] eoi_bcast_vec
);
    logic [NUM_VEC-1:0] irr_q, isr_q, tmr_q;
    logic [NUM_VEC-1:0] irr_d, isr_d, tmr_d;
    logic [VEC_W-1:0]   tpr_q;
    logic [SVR_W-1:0]   svr_q;
    logic               pend_q, reeval_q;
    logic               irr_any, isr_any, pass;
    logic [VEC_W-1:0]   irr_top, isr_top;
    logic               sw_en, ack_take, eoi_hit, reeval_d;

    hi_bit_find #(.N(NUM_VEC)) u_irr_find (.vec_i(irr_q), .any_o(irr_any), .idx_o(irr_top));
    hi_bit_find #(.N(NUM_VEC)) u_isr_find (.vec_i(isr_q), .any_o(isr_any), .idx_o(isr_top));

    prio_gate #(.VEC_W(VEC_W), .CLS_LSB(CLS_LSB)) u_gate (
        .tpr_i(tpr_q), .isr_any_i(isr_any), .isr_top_i(isr_top),
        .irr_any_i(irr_any), .irr_top_i(irr_top), .pass_o(pass)
    );

    assign sw_en    = svr_q[SVR_EN_BIT];
    assign ack_take = ack_req && sw_en && pass;
    assign eoi_hit  = eoi_req && isr_any;
    assign reeval_d = (req_valid && req_level) || ack_req || eoi_req || tpr_we || svr_we;
    assign irq_pending = pend_q && sw_en;

    // next-state of the three vector arrays
    always_comb begin
        irr_d = irr_q;
        isr_d = isr_q;
        tmr_d = tmr_q;
        if (ack_take) begin
            irr_d[irr_top] = 1'b0;
            isr_d[irr_top] = 1'b1;
        end
        if (eoi_hit)
            isr_d[isr_top] = 1'b0;
        if (req_valid) begin
            irr_d[req_vec] = 1'b1;
            tmr_d[req_vec] = req_level;
        end
    end

    // array and control register state
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irr_q <= '0;
            isr_q <= '0;
            tmr_q <= '0;
            tpr_q <= '0;
            svr_q <= SVR_RESET;
        end else begin
            irr_q <= irr_d;
            isr_q <= isr_d;
            tmr_q <= tmr_d;
            if (tpr_we)
                tpr_q <= {tpr_wdata[TP_W-1:0], {CLS_LSB{1'b0}}};
            if (svr_we)
                svr_q <= svr_wdata;
        end
    end

    // pending line: recomputed one cycle after a re-evaluating event
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            reeval_q <= 1'b0;
            pend_q   <= 1'b0;
        end else begin
            reeval_q <= reeval_d;
            if (reeval_q)
                pend_q <= pass;
        end
    end

    // acknowledge response, new-request flag and EOI broadcast
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ack_rsp_valid   <= 1'b0;
            ack_rsp_none    <= 1'b0;
            ack_rsp_vec     <= '0;
            req_fresh       <= 1'b0;
            eoi_bcast_valid <= 1'b0;
            eoi_bcast_vec   <= '0;
        end else begin
            ack_rsp_valid <= ack_req;
            ack_rsp_none  <= ack_req && !(sw_en && irr_any);
            if (!(sw_en && irr_any))
                ack_rsp_vec <= '0;
            else if (pass)
                ack_rsp_vec <= irr_top;
            else
                ack_rsp_vec <= svr_q[VEC_W-1:0];
            req_fresh       <= req_valid && !irr_q[req_vec];
            eoi_bcast_valid <= eoi_hit && tmr_q[isr_top] && !svr_q[SVR_DEOI_BIT];
            eoi_bcast_vec   <= isr_top;
        end
    end

    AST_OFF_GIVES_NONE: assert property (@(posedge clk) disable iff (!rst_n)
        ack_rsp_valid && !$past(svr_q[SVR_EN_BIT]) |-> ack_rsp_none); // R2
    AST_FRESH_FROM_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        req_fresh |-> $past(req_valid)); // R4
    AST_SPUR_KEEPS_STATE: assert property (@(posedge clk) disable iff (!rst_n)
        ack_req && sw_en && irr_any && !pass && !req_valid && !eoi_req
        |=> irr_q == $past(irr_q) && isr_q == $past(isr_q)); // R8
    AST_GRANT_MOVES_BIT: assert property (@(posedge clk) disable iff (!rst_n)
        ack_take && !req_valid && !eoi_req
        |=> isr_q[$past(irr_top)] && !irr_q[$past(irr_top)]); // R9
    AST_EOI_CLEARS_TOP: assert property (@(posedge clk) disable iff (!rst_n)
        eoi_hit && !ack_req |=> !isr_q[$past(isr_top)]); // R10
    AST_BCAST_LEVEL_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        eoi_bcast_valid |-> tmr_q[eoi_bcast_vec] && !$past(svr_q[SVR_DEOI_BIT])); // R11
endmodule

// File: tb/tb_intr_accept_unit.sv
module tb_intr_accept_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0, req_level = 1'b0;
    logic [7:0]  req_vec = '0;
    logic        ack_req = 1'b0, eoi_req = 1'b0, tpr_we = 1'b0, svr_we = 1'b0;
    logic [7:0]  tpr_wdata = '0;
    logic [12:0] svr_wdata = '0;
    logic        irq_pending, req_fresh, ack_rsp_valid, ack_rsp_none, eoi_bcast_valid;
    logic [7:0]  ack_rsp_vec, eoi_bcast_vec;
    int total = 0, bad = 0;
    bit done = 0;

    always #10 clk = ~clk;

    intr_accept_unit dut (.*);

    task automatic chk(input bit ok, input string rq, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
        end
    endtask

    task automatic chk_pend(input string rq, input bit exp);
        chk(irq_pending == exp, rq, irq_pending, exp);
    endtask

    task automatic do_req(input logic [7:0] v, input bit lvl, output bit fresh);
        @(negedge clk); req_valid = 1; req_vec = v; req_level = lvl;
        @(negedge clk); req_valid = 0; fresh = req_fresh;
        @(negedge clk);
    endtask

    task automatic do_ack(output bit none, output logic [7:0] vec);
        @(negedge clk); ack_req = 1;
        @(negedge clk); ack_req = 0; none = ack_rsp_none; vec = ack_rsp_vec;
        @(negedge clk);
    endtask

    task automatic do_eoi(output bit bv, output logic [7:0] bvec);
        @(negedge clk); eoi_req = 1;
        @(negedge clk); eoi_req = 0; bv = eoi_bcast_valid; bvec = eoi_bcast_vec;
        @(negedge clk);
    endtask

    task automatic wr_tpr(input logic [7:0] d);
        @(negedge clk); tpr_we = 1; tpr_wdata = d;
        @(negedge clk); tpr_we = 0;
        @(negedge clk);
    endtask

    task automatic wr_svr(input logic [12:0] d);
        @(negedge clk); svr_we = 1; svr_wdata = d;
        @(negedge clk); svr_we = 0;
        @(negedge clk);
    endtask

    task automatic expect_ack(input string rq, input bit enone, input logic [7:0] evec);
        bit n; logic [7:0] v;
        do_ack(n, v);
        chk(n == enone, rq, n, enone);
        if (!enone) chk(v == evec, rq, v, evec);
    endtask

    task automatic expect_eoi(input string rq, input bit ebv, input logic [7:0] evec);
        bit b; logic [7:0] v;
        do_eoi(b, v);
        chk(b == ebv, rq, b, ebv);
        if (ebv) chk(v == evec, rq, v, evec);
    endtask

    task automatic t_reset;
        chk_pend("R1 pending after reset", 0);
        expect_ack("R1 ack after reset", 1, 0);
    endtask

    task automatic t_enable;
        bit f;
        do_req(8'h40, 1, f);
        chk_pend("R2 no pending while disabled", 0);
        expect_ack("R2 ack none while disabled", 1, 0);
        wr_svr(13'h1FF);
        chk_pend("R3 pending after enable write", 1);
        expect_ack("R9 grant 0x40", 0, 8'h40);
        chk_pend("R3 pending drops after grant", 0);
        expect_eoi("R11 level broadcast", 1, 8'h40);
        expect_ack("R12 ack with empty request array", 1, 0);
    endtask

    task automatic t_edge_and_order;
        bit f;
        do_req(8'h50, 0, f);
        chk(f == 1, "R4 fresh on first request", f, 1);
        chk_pend("R3 edge request leaves pending", 0);
        do_req(8'h50, 0, f);
        chk(f == 0, "R4 not fresh on repeat", f, 0);
        do_req(8'h30, 1, f);
        chk_pend("R3 level request re-evaluates", 1);
        expect_ack("R5 highest vector first", 0, 8'h50);
        expect_ack("R7 in-service class blocks, R8 spurious", 0, 8'hFF);
        chk_pend("R7 pending low while blocked", 0);
        expect_eoi("R11 edge vector no broadcast", 0, 0);
        chk_pend("R10 eoi lowers priority", 1);
        expect_ack("R10 grant after eoi", 0, 8'h30);
        expect_eoi("R11 broadcast 0x30", 1, 8'h30);
    endtask

    task automatic t_task_prio;
        bit f;
        wr_tpr(8'hA5);
        do_req(8'h5F, 1, f);
        chk_pend("R6 equal class blocked", 0);
        expect_ack("R8 spurious default", 0, 8'hFF);
        wr_svr(13'h1E7);
        expect_ack("R8 spurious from register", 0, 8'hE7);
        do_req(8'h60, 1, f);
        chk_pend("R6 higher class passes, low nibble kept", 1);
        expect_ack("R5 grant 0x60", 0, 8'h60);
        wr_tpr(8'h07);
        expect_ack("R7 task priority dominates", 0, 8'hE7);
        wr_tpr(8'h00);
        expect_ack("R7 in-service dominates", 0, 8'hE7);
        wr_svr(13'h11E7);
        expect_eoi("R11 directed eoi suppresses", 0, 0);
        chk_pend("R10 pending after retire", 1);
        expect_ack("R9 grant 0x5F", 0, 8'h5F);
        expect_ack("R12 none after drain", 1, 0);
        expect_eoi("R11 directed no broadcast", 0, 0);
        expect_eoi("R10 eoi with empty in-service", 0, 0);
        chk_pend("R10 nothing pending", 0);
    endtask

    task automatic t_zero_class;
        bit f;
        wr_svr(13'h1FF);
        do_req(8'h05, 1, f);
        chk_pend("R6 zero priority passes class 0", 1);
        expect_ack("R6 grant 0x05", 0, 8'h05);
        expect_eoi("R11 broadcast 0x05", 1, 8'h05);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=hang expected=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        t_reset();
        t_enable();
        t_edge_and_order();
        t_task_prio();
        t_zero_class();
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule